// File: doc/BRIEF.md
# Video Line Sync Waveform Sequencer

This block plays out the sync and blanking waveform of a video raster one pixel per clock. A pixel counter sweeps each line and a line counter sweeps each frame. For every line, a small table of ascending line breakpoints, each paired with a line-type code, chooses which waveform the line carries. Each waveform is an ordered list of states. A state lasts either a fixed ramp length or a span derived from the programmed timing values. The state in force sets a 2-bit level code, a ramp indication and the pass-through of input pixel data.

High-definition line types start every line with a tri-level sync: a fall to the negative tip, a rise through blank to the positive peak, and a return to blank. Standard-definition line types start every line with the leading edge of a negative-going bi-level sync, and every edge lasts two pixels. A downstream digital-to-analog stage maps the level code to currents. Timing inputs are static while the block runs and change only under reset.

Top module: `lsq_line_sequencer`

## Requirements
- R1: `pix_o` counts 0, 1, … up to `cfg_total_pix`−1 and then returns to 0 on the following clock.
- R2: `line_o` starts at 1, increases by one on every pixel wrap, and after reaching `cfg_frame_lines` returns to 1.
- R3: The line type is the 3-bit type of the lowest table entry whose line value is strictly greater than `line_o`. If no entry is greater, the last entry's type applies. Entry i occupies bits [i*LINE_W +: LINE_W] of `cfg_bp_line` and bits [i*3 +: 3] of `cfg_bp_type`. Type codes are 0 HD active, 1 HD full normal sync, 2 HD broad+tri-level, 3 SD double equalizing, 4 SD double broad, 5 SD sync+active. Codes 6 and 7 act as code 1.
- R4: HD lines (types 0–2) open with pixels [0,2) ramp blank→negative, [2,S−2) negative, [S−2,S+2) ramp negative→positive, [S+2,2S−2) positive and [2S−2,2S) ramp positive→blank, where S = `cfg_sync_w`.
- R5: Type 0 is blank from 2S to `cfg_act_start`, video until `cfg_total_pix`−`cfg_tail_w`, and blank for the final `cfg_tail_w` pixels.
- R6: Type 1 holds one level from 2S to the end of the line: video when `cfg_pass_en` is 1, blank when it is 0.
- R7: Type 2 is blank from 2S to H = `cfg_half_w`. It then ramps blank→negative over [H,H+2), stays negative until H+B−2 with B = `cfg_broad_w`, ramps negative→blank over [H+B−2,H+B), and is blank to the end of the line.
- R8: Types 3 and 4 repeat a half-line of H pixels twice, with pulse width P (`cfg_eq_w` for type 3, `cfg_broad_w` for type 4). At offset x within the half: [0,1) ramp blank→negative, [1,1+P) negative, [1+P,3+P) ramp negative→blank, [3+P,H−1) blank, [H−1,H) ramp blank→negative. They never show the positive level.
- R9: Type 5 is [0,1) ramp blank→negative, [1,1+S) negative, [1+S,3+S) ramp negative→blank, blank until `cfg_act_start`, video until T−`cfg_tail_w`−1 with T = `cfg_total_pix`, blank until T−1, and a ramp blank→negative on the last pixel.
- R10: `lvl_o` encodes 00 blank, 01 negative sync tip, 10 positive tri-level peak, 11 video. During a ramp `ramp_o` is 1, `lvl_o` is the level being approached and `ramp_from_o` the level being left. Outside ramps `ramp_o` is 0 and `ramp_from_o` equals `lvl_o`.
- R11: `act_o` is 1 exactly when `lvl_o` is video. In that case `vid_o` equals `pix_in`; otherwise `vid_o` is 0.
- R12: While `rst_n` is low, `pix_o` is 0, `line_o` is 1, and the outputs show the first state of line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_total_pix | input | PIX_W | Pixels per line |
| cfg_frame_lines | input | LINE_W | Lines per frame |
| cfg_sync_w | input | PIX_W | HD half-pulse width / SD normal sync width |
| cfg_half_w | input | PIX_W | Half-line length |
| cfg_act_start | input | PIX_W | First video pixel of an active line |
| cfg_tail_w | input | PIX_W | Blank span after video |
| cfg_broad_w | input | PIX_W | Broad pulse width |
| cfg_eq_w | input | PIX_W | Equalizing pulse width |
| cfg_pass_en | input | 1 | Video pass on HD full normal sync lines |
| cfg_bp_line | input | NUM_BP*LINE_W | Ascending breakpoint lines |
| cfg_bp_type | input | NUM_BP*3 | Line type for each breakpoint |
| pix_in | input | DATA_W | Input pixel data |
| pix_o | output | PIX_W | Pixel counter |
| line_o | output | LINE_W | Line counter |
| lvl_o | output | 2 | Level code |
| ramp_o | output | 1 | Ramp state in force |
| ramp_from_o | output | 2 | Level left by the ramp |
| act_o | output | 1 | Video region flag |
| vid_o | output | DATA_W | Passed pixel data, 0 outside video |

## Verification
The assertions assume the timing inputs hold steady between resets. They also assume every derived state span is at least one pixel and that the spans of each line type add up to exactly `cfg_total_pix`, so the final state ends on the counter wrap. The stimulus meets this by changing configuration only while reset is held. It uses a 64-pixel line with widths chosen so that every HD and SD state span is positive and each half-line is exactly half the line.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

   localparam int SEG_IDX_W = 4;
   localparam int LTYPE_W   = 3;
   localparam int HD_HEAD_N = 5;
   localparam int SD_HALF_N = 5;

   typedef enum logic [1:0] {
      LV_BLANK = 2'b00,
      LV_NEG   = 2'b01,
      LV_POS   = 2'b10,
      LV_VIDEO = 2'b11
   } lsq_level_e;

   typedef enum logic [LTYPE_W-1:0] {
      LT_HD_ACTIVE = 3'd0,
      LT_HD_NORM   = 3'd1,
      LT_HD_BROAD  = 3'd2,
      LT_SD_EQ     = 3'd3,
      LT_SD_BROAD  = 3'd4,
      LT_SD_ACTIVE = 3'd5
   } lsq_ltype_e;

endpackage

// File: rtl/lsq_pix_line_ctr.sv
module lsq_pix_line_ctr #(
   parameter int PIX_W  = 12,
   parameter int LINE_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIX_W-1:0]  total_pix,
   input  logic [LINE_W-1:0] frame_lines,
   output logic [PIX_W-1:0]  pix,
   output logic [LINE_W-1:0] line,
   output logic              eol
);

   localparam logic [LINE_W-1:0] FIRST_LINE = LINE_W'(1);
   localparam logic [PIX_W-1:0]  PIX_ONE    = PIX_W'(1);

   generate
      if (PIX_W < 4) begin : g_bad_pix_w
         $error("PIX_W too small for the fixed ramp states");
      end
      if (LINE_W < 2) begin : g_bad_line_w
         $error("LINE_W too small");
      end
   endgenerate

   assign eol = (pix == total_pix - PIX_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix  <= '0;
         line <= FIRST_LINE;
      end else if (eol) begin
         pix  <= '0;
         line <= (line >= frame_lines) ? FIRST_LINE : line + FIRST_LINE;
      end else begin
         pix  <= pix + PIX_ONE;
      end
   end

   // R1
   pix_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix < total_pix);

   // R1
   pix_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eol |=> (pix == '0));

   // R2
   line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eol && (line < frame_lines)) |=> (line == $past(line) + FIRST_LINE));

   // R2
   line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eol |=> $stable(line));

endmodule

// File: rtl/lsq_type_sel.sv
module lsq_type_sel
   import lsq_pkg::*;
#(
   parameter int LINE_W = 11,
   parameter int NUM_BP = 4
) (
   input  logic [LINE_W-1:0]         line,
   input  logic [NUM_BP*LINE_W-1:0]  bp_line,
   input  logic [NUM_BP*LTYPE_W-1:0] bp_type,
   output lsq_ltype_e                ltype
);

   generate
      if (NUM_BP < 1) begin : g_bad_bp
         $error("NUM_BP must be at least 1");
      end
   endgenerate

   logic [LINE_W-1:0]  bpl [NUM_BP];
   logic [LTYPE_W-1:0] bpt [NUM_BP];
   logic [NUM_BP-1:0]  above;
   logic [LTYPE_W-1:0] pick;

   generate
      for (genvar g = 0; g < NUM_BP; g++) begin : g_entry
         assign bpl[g]   = bp_line[g*LINE_W +: LINE_W];
         assign bpt[g]   = bp_type[g*LTYPE_W +: LTYPE_W];
         assign above[g] = (bpl[g] > line);
      end
   endgenerate

   always_comb begin
      pick = bpt[NUM_BP-1];
      for (int i = NUM_BP - 1; i >= 0; i--) begin
         if (above[i]) pick = bpt[i];
      end
   end

   assign ltype = (pick > LTYPE_W'(5)) ? LT_HD_NORM : lsq_ltype_e'(pick);

endmodule

// File: rtl/lsq_seg_rom.sv
module lsq_seg_rom
   import lsq_pkg::*;
#(
   parameter int PIX_W        = 12,
   parameter int RAMP_HD_EDGE = 2,
   parameter int RAMP_HD_MID  = 4,
   parameter int RAMP_SD      = 2
) (
   input  lsq_ltype_e           ltype,
   input  logic [SEG_IDX_W-1:0] idx,
   input  logic [PIX_W-1:0]     total_pix,
   input  logic [PIX_W-1:0]     sync_w,
   input  logic [PIX_W-1:0]     half_w,
   input  logic [PIX_W-1:0]     act_start,
   input  logic [PIX_W-1:0]     tail_w,
   input  logic [PIX_W-1:0]     broad_w,
   input  logic [PIX_W-1:0]     eq_w,
   input  logic                 pass_en,
   output logic [PIX_W-1:0]     seg_len,
   output lsq_level_e           seg_from,
   output lsq_level_e           seg_lvl,
   output logic                 seg_ramp,
   output logic                 seg_last
);

   generate
      if (RAMP_HD_EDGE < 1) begin : g_bad_hd_edge
         $error("RAMP_HD_EDGE must be at least 1");
      end
      if ((RAMP_HD_MID < 2) || (RAMP_HD_MID % 2 != 0)) begin : g_bad_hd_mid
         $error("RAMP_HD_MID must be even and at least 2");
      end
      if (RAMP_SD < 2) begin : g_bad_sd
         $error("RAMP_SD must be at least 2");
      end
   endgenerate

   localparam logic [PIX_W-1:0] HD_EDGE_L = PIX_W'(RAMP_HD_EDGE);
   localparam logic [PIX_W-1:0] HD_MID_L  = PIX_W'(RAMP_HD_MID);
   localparam logic [PIX_W-1:0] HD_CUT_L  = PIX_W'(RAMP_HD_EDGE + RAMP_HD_MID / 2);
   localparam logic [PIX_W-1:0] SD_LEAD_L = PIX_W'(RAMP_SD / 2);
   localparam logic [PIX_W-1:0] SD_TRL_L  = PIX_W'(RAMP_SD - RAMP_SD / 2);
   localparam logic [PIX_W-1:0] SD_FULL_L = PIX_W'(RAMP_SD);
   localparam logic [SEG_IDX_W-1:0] HD_HEAD_I = SEG_IDX_W'(HD_HEAD_N);
   localparam logic [SEG_IDX_W-1:0] SD_HALF_I = SEG_IDX_W'(SD_HALF_N);
   localparam logic [SEG_IDX_W-1:0] SD_LAST_I = SEG_IDX_W'(2 * SD_HALF_N - 1);

   typedef struct packed {
      logic [PIX_W-1:0] len;
      lsq_level_e       from;
      lsq_level_e       lvl;
      logic             ramp;
      logic             last;
   } seg_t;

   function automatic seg_t mk(input logic [PIX_W-1:0] len, input lsq_level_e from,
                               input lsq_level_e lvl, input logic ramp, input logic last);
      seg_t r;
      r.len  = len;
      r.from = from;
      r.lvl  = lvl;
      r.ramp = ramp;
      r.last = last;
      return r;
   endfunction

   logic [PIX_W-1:0]     two_sync;
   logic [PIX_W-1:0]     sync_inner;
   logic [PIX_W-1:0]     sd_pulse;
   logic [SEG_IDX_W-1:0] half_k;
   logic                 sd_last;
   lsq_level_e           pass_lvl;
   seg_t                 seg;

   assign two_sync   = sync_w << 1;
   assign sync_inner = sync_w - HD_CUT_L;
   assign sd_pulse   = (ltype == LT_SD_EQ) ? eq_w : broad_w;
   assign half_k     = (idx >= SD_HALF_I) ? idx - SD_HALF_I : idx;
   assign sd_last    = (idx == SD_LAST_I);
   assign pass_lvl   = pass_en ? LV_VIDEO : LV_BLANK;

   always_comb begin
      seg = mk(total_pix, LV_BLANK, LV_BLANK, 1'b0, 1'b1);
      case (ltype)
         LT_HD_ACTIVE, LT_HD_NORM, LT_HD_BROAD: begin
            if (idx < HD_HEAD_I) begin
               case (idx)
                  4'd0:    seg = mk(HD_EDGE_L,  LV_BLANK, LV_NEG,   1'b1, 1'b0);
                  4'd1:    seg = mk(sync_inner, LV_NEG,   LV_NEG,   1'b0, 1'b0);
                  4'd2:    seg = mk(HD_MID_L,   LV_NEG,   LV_POS,   1'b1, 1'b0);
                  4'd3:    seg = mk(sync_inner, LV_POS,   LV_POS,   1'b0, 1'b0);
                  default: seg = mk(HD_EDGE_L,  LV_POS,   LV_BLANK, 1'b1, 1'b0);
               endcase
            end else if (ltype == LT_HD_ACTIVE) begin
               case (idx)
                  4'd5:    seg = mk(act_start - two_sync, LV_BLANK, LV_BLANK, 1'b0, 1'b0);
                  4'd6:    seg = mk(total_pix - act_start - tail_w, LV_VIDEO, LV_VIDEO, 1'b0, 1'b0);
                  default: seg = mk(tail_w, LV_BLANK, LV_BLANK, 1'b0, 1'b1);
               endcase
            end else if (ltype == LT_HD_NORM) begin
               seg = mk(total_pix - two_sync, pass_lvl, pass_lvl, 1'b0, 1'b1);
            end else begin
               case (idx)
                  4'd5:    seg = mk(half_w - two_sync, LV_BLANK, LV_BLANK, 1'b0, 1'b0);
                  4'd6:    seg = mk(HD_EDGE_L, LV_BLANK, LV_NEG, 1'b1, 1'b0);
                  4'd7:    seg = mk(broad_w - (HD_EDGE_L << 1), LV_NEG, LV_NEG, 1'b0, 1'b0);
                  4'd8:    seg = mk(HD_EDGE_L, LV_NEG, LV_BLANK, 1'b1, 1'b0);
                  default: seg = mk(total_pix - half_w - broad_w, LV_BLANK, LV_BLANK, 1'b0, 1'b1);
               endcase
            end
         end
         LT_SD_EQ, LT_SD_BROAD: begin
            case (half_k)
               4'd0:    seg = mk(SD_LEAD_L, LV_BLANK, LV_NEG,   1'b1, 1'b0);
               4'd1:    seg = mk(sd_pulse,  LV_NEG,   LV_NEG,   1'b0, 1'b0);
               4'd2:    seg = mk(SD_FULL_L, LV_NEG,   LV_BLANK, 1'b1, 1'b0);
               4'd3:    seg = mk(half_w - sd_pulse - (SD_FULL_L << 1), LV_BLANK, LV_BLANK, 1'b0, 1'b0);
               default: seg = mk(SD_TRL_L,  LV_BLANK, LV_NEG,   1'b1, sd_last);
            endcase
         end
         LT_SD_ACTIVE: begin
            case (idx)
               4'd0:    seg = mk(SD_LEAD_L, LV_BLANK, LV_NEG,   1'b1, 1'b0);
               4'd1:    seg = mk(sync_w,    LV_NEG,   LV_NEG,   1'b0, 1'b0);
               4'd2:    seg = mk(SD_FULL_L, LV_NEG,   LV_BLANK, 1'b1, 1'b0);
               4'd3:    seg = mk(act_start - sync_w - SD_FULL_L - SD_LEAD_L, LV_BLANK, LV_BLANK, 1'b0, 1'b0);
               4'd4:    seg = mk(total_pix - act_start - tail_w - SD_TRL_L, LV_VIDEO, LV_VIDEO, 1'b0, 1'b0);
               4'd5:    seg = mk(tail_w,    LV_BLANK, LV_BLANK, 1'b0, 1'b0);
               default: seg = mk(SD_TRL_L,  LV_BLANK, LV_NEG,   1'b1, 1'b1);
            endcase
         end
         default: seg = mk(total_pix, LV_BLANK, LV_BLANK, 1'b0, 1'b1);
      endcase
   end

   assign seg_len  = seg.len;
   assign seg_from = seg.from;
   assign seg_lvl  = seg.lvl;
   assign seg_ramp = seg.ramp;
   assign seg_last = seg.last;

endmodule

// File: rtl/lsq_seg_engine.sv
module lsq_seg_engine
   import lsq_pkg::*;
#(
   parameter int PIX_W = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 eol,
   input  logic [PIX_W-1:0]     seg_len,
   input  logic                 seg_last,
   output logic [SEG_IDX_W-1:0] idx
);

   localparam logic [PIX_W-1:0]     PIX_ONE = PIX_W'(1);
   localparam logic [SEG_IDX_W-1:0] IDX_ONE = SEG_IDX_W'(1);

   logic [PIX_W-1:0] cnt_q;
   logic             seg_done;

   assign seg_done = (cnt_q == seg_len - PIX_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx   <= '0;
         cnt_q <= '0;
      end else if (eol) begin
         idx   <= '0;
         cnt_q <= '0;
      end else if (seg_done && !seg_last) begin
         idx   <= idx + IDX_ONE;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + PIX_ONE;
      end
   end

   // R5, R6, R7, R8, R9: the state spans of a line end exactly on the wrap
   row_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eol |-> (seg_last && seg_done));

   // R1: a new line always begins at its first state
   line_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eol |=> (idx == '0));

endmodule

// File: rtl/lsq_line_sequencer.sv
module lsq_line_sequencer
   import lsq_pkg::*;
#(
   parameter int PIX_W        = 12,
   parameter int LINE_W       = 11,
   parameter int NUM_BP       = 4,
   parameter int DATA_W       = 10,
   parameter int RAMP_HD_EDGE = 2,
   parameter int RAMP_HD_MID  = 4,
   parameter int RAMP_SD      = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [PIX_W-1:0]         cfg_total_pix,
   input  logic [LINE_W-1:0]        cfg_frame_lines,
   input  logic [PIX_W-1:0]         cfg_sync_w,
   input  logic [PIX_W-1:0]         cfg_half_w,
   input  logic [PIX_W-1:0]         cfg_act_start,
   input  logic [PIX_W-1:0]         cfg_tail_w,
   input  logic [PIX_W-1:0]         cfg_broad_w,
   input  logic [PIX_W-1:0]         cfg_eq_w,
   input  logic                     cfg_pass_en,
   input  logic [NUM_BP*LINE_W-1:0] cfg_bp_line,
   input  logic [NUM_BP*3-1:0]      cfg_bp_type,
   input  logic [DATA_W-1:0]        pix_in,
   output logic [PIX_W-1:0]         pix_o,
   output logic [LINE_W-1:0]        line_o,
   output logic [1:0]               lvl_o,
   output logic                     ramp_o,
   output logic [1:0]               ramp_from_o,
   output logic                     act_o,
   output logic [DATA_W-1:0]        vid_o
);

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("DATA_W must be at least 1");
      end
   endgenerate

   logic                 eol;
   lsq_ltype_e           ltype;
   logic [SEG_IDX_W-1:0] idx;
   logic [PIX_W-1:0]     seg_len;
   lsq_level_e           seg_from;
   lsq_level_e           seg_lvl;
   logic                 seg_ramp;
   logic                 seg_last;

   lsq_pix_line_ctr #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_ctr (
      .clk         (clk),
      .rst_n       (rst_n),
      .total_pix   (cfg_total_pix),
      .frame_lines (cfg_frame_lines),
      .pix         (pix_o),
      .line        (line_o),
      .eol         (eol)
   );

   lsq_type_sel #(.LINE_W(LINE_W), .NUM_BP(NUM_BP)) u_sel (
      .line    (line_o),
      .bp_line (cfg_bp_line),
      .bp_type (cfg_bp_type),
      .ltype   (ltype)
   );

   lsq_seg_engine #(.PIX_W(PIX_W)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .eol      (eol),
      .seg_len  (seg_len),
      .seg_last (seg_last),
      .idx      (idx)
   );

   lsq_seg_rom #(
      .PIX_W        (PIX_W),
      .RAMP_HD_EDGE (RAMP_HD_EDGE),
      .RAMP_HD_MID  (RAMP_HD_MID),
      .RAMP_SD      (RAMP_SD)
   ) u_rom (
      .ltype     (ltype),
      .idx       (idx),
      .total_pix (cfg_total_pix),
      .sync_w    (cfg_sync_w),
      .half_w    (cfg_half_w),
      .act_start (cfg_act_start),
      .tail_w    (cfg_tail_w),
      .broad_w   (cfg_broad_w),
      .eq_w      (cfg_eq_w),
      .pass_en   (cfg_pass_en),
      .seg_len   (seg_len),
      .seg_from  (seg_from),
      .seg_lvl   (seg_lvl),
      .seg_ramp  (seg_ramp),
      .seg_last  (seg_last)
   );

   assign lvl_o       = seg_lvl;
   assign ramp_o      = seg_ramp;
   assign ramp_from_o = seg_from;
   assign act_o       = (seg_lvl == LV_VIDEO);
   assign vid_o       = act_o ? pix_in : '0;

   // R4: every line opens with a falling sync edge leaving blank
   sync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_o == '0) |-> (ramp_o && (ramp_from_o == 2'b00) && (lvl_o == 2'b01)));

   // R8
   sd_no_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ltype == LT_SD_EQ) || (ltype == LT_SD_BROAD)) |-> ((lvl_o != 2'b10) && (ramp_from_o != 2'b10)));

   // R3: the line type holds for the whole line
   type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eol |=> $stable(ltype));

   // R11
   act_no_ramp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_o |-> !ramp_o);

endmodule

// File: tb/tb_lsq_line_sequencer.sv
module tb_lsq_line_sequencer;

   localparam int CLK_PERIOD = 10;
   localparam int PIX_W  = 12;
   localparam int LINE_W = 11;
   localparam int NUM_BP = 4;
   localparam int DATA_W = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;

   int t_total = 64, t_sync = 6, t_act = 20, t_tail = 6;
   int t_half = 32, t_broad = 12, t_eq = 3, t_frame = 8;
   bit t_pass = 1'b0;
   int bpl [NUM_BP];
   int bpt [NUM_BP];
   logic [DATA_W-1:0] din = '0;

   logic [PIX_W-1:0]  pix_o;
   logic [LINE_W-1:0] line_o;
   logic [1:0]        lvl_o;
   logic              ramp_o;
   logic [1:0]        ramp_from_o;
   logic              act_o;
   logic [DATA_W-1:0] vid_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lsq_line_sequencer #(.PIX_W(PIX_W), .LINE_W(LINE_W), .NUM_BP(NUM_BP), .DATA_W(DATA_W)) dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .cfg_total_pix   (PIX_W'(t_total)),
      .cfg_frame_lines (LINE_W'(t_frame)),
      .cfg_sync_w      (PIX_W'(t_sync)),
      .cfg_half_w      (PIX_W'(t_half)),
      .cfg_act_start   (PIX_W'(t_act)),
      .cfg_tail_w      (PIX_W'(t_tail)),
      .cfg_broad_w     (PIX_W'(t_broad)),
      .cfg_eq_w        (PIX_W'(t_eq)),
      .cfg_pass_en     (t_pass),
      .cfg_bp_line     ({LINE_W'(bpl[3]), LINE_W'(bpl[2]), LINE_W'(bpl[1]), LINE_W'(bpl[0])}),
      .cfg_bp_type     ({3'(bpt[3]), 3'(bpt[2]), 3'(bpt[1]), 3'(bpt[0])}),
      .pix_in          (din),
      .pix_o           (pix_o),
      .line_o          (line_o),
      .lvl_o           (lvl_o),
      .ramp_o          (ramp_o),
      .ramp_from_o     (ramp_from_o),
      .act_o           (act_o),
      .vid_o           (vid_o)
   );

   // R3: lowest entry above the line wins, else the last; codes 6 and 7 act as 1
   function automatic int exp_type(input int ln);
      int ty = bpt[NUM_BP-1];
      for (int i = NUM_BP - 1; i >= 0; i--) if (bpl[i] > ln) ty = bpt[i];
      return (ty > 5) ? 1 : ty;
   endfunction

   function automatic void exp_at(input int ty, input int p, output int lv, output int fr, output bit rp);
      int x, w;
      lv = 0; fr = 0; rp = 0;
      if (ty <= 2 && p < 2 * t_sync) begin
         if (p < 2)                   begin lv = 1; fr = 0; rp = 1; end
         else if (p < t_sync - 2)     lv = 1;
         else if (p < t_sync + 2)     begin lv = 2; fr = 1; rp = 1; end
         else if (p < 2 * t_sync - 2) lv = 2;
         else                         begin lv = 0; fr = 2; rp = 1; end
      end else if (ty == 0) begin
         lv = (p >= t_act && p < t_total - t_tail) ? 3 : 0;
      end else if (ty == 1) begin
         lv = t_pass ? 3 : 0;
      end else if (ty == 2) begin
         if (p < t_half)                    lv = 0;
         else if (p < t_half + 2)           begin lv = 1; fr = 0; rp = 1; end
         else if (p < t_half + t_broad - 2) lv = 1;
         else if (p < t_half + t_broad)     begin lv = 0; fr = 1; rp = 1; end
         else                               lv = 0;
      end else if (ty == 3 || ty == 4) begin
         x = (p >= t_half) ? p - t_half : p;
         w = (ty == 3) ? t_eq : t_broad;
         if (x < 1)               begin lv = 1; fr = 0; rp = 1; end
         else if (x < 1 + w)      lv = 1;
         else if (x < 3 + w)      begin lv = 0; fr = 1; rp = 1; end
         else if (x < t_half - 1) lv = 0;
         else                     begin lv = 1; fr = 0; rp = 1; end
      end else begin
         if (p < 1)                         begin lv = 1; fr = 0; rp = 1; end
         else if (p < 1 + t_sync)           lv = 1;
         else if (p < 3 + t_sync)           begin lv = 0; fr = 1; rp = 1; end
         else if (p < t_act)                lv = 0;
         else if (p < t_total - t_tail - 1) lv = 3;
         else if (p < t_total - 1)          lv = 0;
         else                               begin lv = 1; fr = 0; rp = 1; end
      end
      if (!rp) fr = lv;
   endfunction

   function automatic string type_tag(input int ty);
      case (ty)
         0: return "R5 R4";
         1: return "R6 R4";
         2: return "R7 R4";
         3, 4: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check_line(input int ln);
      int ty = exp_type(ln);
      int lv, fr;
      bit rp;
      bit bad = 0, cbad = 0;
      string msg = "", cmsg = "";
      logic [DATA_W-1:0] ev;
      for (int p = 0; p < t_total; p++) begin
         exp_at(ty, p, lv, fr, rp);
         ev = (lv == 3) ? din : '0;
         if (!cbad && (int'(pix_o) != p || int'(line_o) != ln)) begin
            cbad = 1;
            cmsg = $sformatf("got pix=%0d line=%0d, expected pix=%0d line=%0d", pix_o, line_o, p, ln);
         end
         if (!bad && (int'(lvl_o) != lv || ramp_o != rp || int'(ramp_from_o) != fr ||
                      act_o != (lv == 3) || vid_o != ev)) begin
            bad = 1;
            msg = $sformatf("line %0d pix %0d: got lvl=%0d ramp=%0d from=%0d act=%0d vid=%0h, expected lvl=%0d ramp=%0d from=%0d act=%0d vid=%0h",
                            ln, p, lvl_o, ramp_o, ramp_from_o, act_o, vid_o, lv, rp, fr, (lv == 3), ev);
         end
         @(negedge clk);
      end
      checks++;
      if (cbad) begin fails++; $display("FAIL R1 R2 counters: %s", cmsg); end
      checks++;
      if (bad) begin fails++; $display("FAIL %s R3 R10 R11 %s", type_tag(ty), msg); end
   endtask

   task automatic run_lines(input int n);
      int ln = 1;
      for (int i = 0; i < n; i++) begin
         check_line(ln);
         ln = (ln == t_frame) ? 1 : ln + 1;
      end
   endtask

   task automatic reset_and_check();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      checks++;
      // R12: counters cleared, first state of line 1 is the falling ramp
      if (pix_o != '0 || line_o != LINE_W'(1) || lvl_o != 2'b01 || !ramp_o ||
          ramp_from_o != 2'b00 || act_o || vid_o != '0) begin
         fails++;
         $display("FAIL R12 reset state: got pix=%0d line=%0d lvl=%0d ramp=%0d from=%0d act=%0d, expected pix=0 line=1 lvl=1 ramp=1 from=0 act=0",
                  pix_o, line_o, lvl_o, ramp_o, ramp_from_o, act_o);
      end
      rst_n = 1'b1;
   endtask

   task automatic set_hd_table();
      t_frame = 8;
      bpl[0] = 2; bpt[0] = 2;
      bpl[1] = 3; bpt[1] = 1;
      bpl[2] = 7; bpt[2] = 0;
      bpl[3] = 9; bpt[3] = 7;
   endtask

   task automatic test_hd_frames();
      @(negedge clk);
      rst_n = 1'b0;
      set_hd_table();
      t_pass = 1'b0;
      din = 10'h155;
      reset_and_check();
      run_lines(2 * t_frame);
   endtask

   task automatic test_hd_pass();
      @(negedge clk);
      rst_n = 1'b0;
      set_hd_table();
      t_pass = 1'b1;
      din = 10'h2AA;
      reset_and_check();
      run_lines(t_frame);
   endtask

   task automatic test_sd_fallthrough();
      @(negedge clk);
      rst_n = 1'b0;
      t_frame = 10;
      t_pass = 1'b0;
      din = 10'h0F3;
      bpl[0] = 3; bpt[0] = 3;
      bpl[1] = 5; bpt[1] = 4;
      bpl[2] = 8; bpt[2] = 5;
      bpl[3] = 8; bpt[3] = 3;
      reset_and_check();
      run_lines(t_frame + 1);
   endtask

   task automatic test_mid_reset();
      @(negedge clk);
      rst_n = 1'b0;
      set_hd_table();
      t_pass = 1'b0;
      din = 10'h3C1;
      reset_and_check();
      repeat (t_total + 17) @(negedge clk);
      reset_and_check();
      run_lines(3);
   endtask

   initial begin
      bpl[0] = 2; bpl[1] = 3; bpl[2] = 7; bpl[3] = 9;
      bpt[0] = 2; bpt[1] = 1; bpt[2] = 0; bpt[3] = 1;
      test_hd_frames();
      test_hd_pass();
      test_sd_fallthrough();
      test_mid_reset();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL R1 watchdog: got run still busy, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule